// File: doc/BRIEF.md
# Accumulator ALU with Carry, Digit-Carry and Zero Flags

This block is the execute stage of a small accumulator-based processor core. It holds an 8-bit working register (W) that the rest of the core can only reach as the implicit operand and destination of ALU operations. Each accepted operation combines W with a second operand, or transforms one operand on its own. The second operand is a value read from the register file, an immediate literal, or W itself. Every operation finishes in a single cycle.

Three flags sit beside W. Carry (C) and Digit Carry (DC) report the carry out of bit 7 and bit 3 in addition. In subtraction they turn into inverted borrow indicators. Zero (Z) reports an all-zero result. Each class of operation updates only its own subset of the flags.

A destination bit picks where the result goes. It is either loaded into W on the clock edge, or offered on a valid/ready write port that carries it back to the register file. The operation input is also valid/ready. An operation bound for W is always accepted. An operation bound for the file is accepted only in the cycle in which the write port is taken (`wr_valid` and `wr_ready` both high). Back-pressure on the write port therefore stalls the operation input, and a stalled operation changes no state. Instruction fetch, decode and the register file storage sit outside this block.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low and after reset is released, `w_q` is 0, `flag_c`, `flag_dc` and `flag_z` are 0, and `wr_valid` is low whenever `op_valid` is low.
- R2: Opcode 0 (add) produces operand + W modulo 256. C is set to the carry out of bit 7, DC to the carry out of bit 3 into bit 4, and Z to (result == 0).
- R3: Opcode 1 (subtract) produces operand − W modulo 256, computed as operand + ~W + 1. C is set to 1 exactly when operand ≥ W (no borrow). DC is set to 1 exactly when operand[3:0] ≥ W[3:0]. Z is set to (result == 0).
- R4: For opcodes 0 to 6, Z after the operation equals 1 exactly when the 8-bit result is zero.
- R5: Opcodes 2 (AND with W), 3 (OR with W), 4 (XOR with W), 5 (complement of operand) and 6 (move operand) update only Z. C and DC keep their values.
- R6: Opcode 7 (rotate left through carry) gives {operand[6:0], C} with the new C = operand[7]. Opcode 8 (rotate right through carry) gives {C, operand[7:1]} with the new C = operand[0]. Both leave Z and DC unchanged.
- R7: `src_sel` picks the operand: 0 = `file_data`, 1 = `lit_data`, 2 = current W, 3 = `file_data`.
- R8: With `dst_file` = 0, an accepted operation loads its result into W at the clock edge, `op_ready` is 1, and `wr_valid` stays low.
- R9: With `dst_file` = 1, `wr_valid` follows `op_valid` and `wr_data` carries the result in the same cycle. W does not change.
- R10: With `dst_file` = 1 and `wr_ready` low, `op_ready` is low, and W and the flags do not change.
- R11: Opcodes 9 to 15 act as a move of the operand to the destination with no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation accepted this cycle when high together with op_valid |
| op_code | input | 4 | Operation select (see R2 to R6, R11) |
| src_sel | input | 2 | Operand source select (see R7) |
| dst_file | input | 1 | 1 = result to write port, 0 = result to W |
| file_data | input | 8 | Register-file operand |
| lit_data | input | 8 | Immediate literal operand |
| wr_valid | output | 1 | Result offered to the register file |
| wr_ready | input | 1 | Register file takes the result |
| wr_data | output | 8 | Result toward the register file |
| w_q | output | 8 | Working register contents |
| flag_c | output | 1 | Carry / inverted borrow flag |
| flag_dc | output | 1 | Digit carry / inverted digit borrow flag |
| flag_z | output | 1 | Zero flag |

## Verification
Addition runs on a low-nibble overflow, a full wrap to zero and a plain sum with no carries, which separates the DC, C and Z paths. Subtraction uses operand greater than, less than and equal to W, plus a case where only the nibble borrows, so the inverted borrow sense of C and of DC is each pinned down on its own. Rotates run with C preset both ways, to show that the carry enters at the correct end and that Z and DC hold. Logical operations run with C and DC set, to show that they hold. The write port is exercised with `wr_ready` high and low, which tells an accepted file write from a stall that must change nothing.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = 4;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_COM = 4'd5,
    OP_MOV = 4'd6,
    OP_RL  = 4'd7,
    OP_RR  = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    SRC_FILE = 2'd0,
    SRC_LIT  = 2'd1,
    SRC_W    = 2'd2,
    SRC_ALT  = 2'd3
  } src_e;

  typedef struct packed {
    logic upd_c;
    logic upd_dc;
    logic upd_z;
  } flag_upd_t;
endpackage

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = NIB_W
) (
  input  logic [3:0]    op,
  input  logic [1:0]    src,
  input  logic [DW-1:0] file_data,
  input  logic [DW-1:0] lit_data,
  input  logic [DW-1:0] w_val,
  input  logic          c_in,
  output logic [DW-1:0] operand,
  output logic [DW-1:0] result,
  output logic          c_out,
  output logic          dc_out,
  output flag_upd_t     upd
);
  logic          is_sub;
  logic [DW-1:0] addend;
  logic [DW:0]   sum_full;
  logic [NW:0]   sum_nib;

  always_comb begin
    unique case (src_e'(src))
      SRC_LIT: operand = lit_data;
      SRC_W:   operand = w_val;
      default: operand = file_data;
    endcase
  end

  // Shared adder: subtraction adds the inverted W with a carry-in of one.
  assign is_sub   = (op == OP_SUB);
  assign addend   = is_sub ? ~w_val : w_val;
  assign sum_full = {1'b0, operand} + {1'b0, addend} + {{DW{1'b0}}, is_sub};
  assign sum_nib  = {1'b0, operand[NW-1:0]} + {1'b0, addend[NW-1:0]} + {{NW{1'b0}}, is_sub};

  always_comb begin
    result = operand;
    c_out  = c_in;
    dc_out = sum_nib[NW];
    upd    = '{upd_c: 1'b0, upd_dc: 1'b0, upd_z: 1'b0};
    case (op)
      OP_ADD, OP_SUB: begin
        result = sum_full[DW-1:0];
        c_out  = sum_full[DW];
        upd    = '{upd_c: 1'b1, upd_dc: 1'b1, upd_z: 1'b1};
      end
      OP_AND: begin result = operand & w_val; upd.upd_z = 1'b1; end
      OP_OR:  begin result = operand | w_val; upd.upd_z = 1'b1; end
      OP_XOR: begin result = operand ^ w_val; upd.upd_z = 1'b1; end
      OP_COM: begin result = ~operand;        upd.upd_z = 1'b1; end
      OP_MOV: begin result = operand;         upd.upd_z = 1'b1; end
      OP_RL: begin
        result    = {operand[DW-2:0], c_in};
        c_out     = operand[DW-1];
        upd.upd_c = 1'b1;
      end
      OP_RR: begin
        result    = {c_in, operand[DW-1:1]};
        c_out     = operand[0];
        upd.upd_c = 1'b1;
      end
      default: result = operand;
    endcase
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  flag_upd_t     upd,
  input  logic          c_new,
  input  logic          dc_new,
  input  logic [DW-1:0] result,
  output logic          c_q,
  output logic          dc_q,
  output logic          z_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q  <= 1'b0;
      dc_q <= 1'b0;
      z_q  <= 1'b0;
    end else if (fire) begin
      if (upd.upd_c)  c_q  <= c_new;
      if (upd.upd_dc) dc_q <= dc_new;
      if (upd.upd_z)  z_q  <= (result == '0);
    end
  end

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(c_q) && $stable(dc_q) && $stable(z_q)));
endmodule

// File: rtl/acc_alu_wreg.sv
module acc_alu_wreg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [3:0]        op_code,
  input  logic [1:0]        src_sel,
  input  logic              dst_file,
  input  logic [DATA_W-1:0] file_data,
  input  logic [DATA_W-1:0] lit_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] w_q,
  output logic              flag_c,
  output logic              flag_dc,
  output logic              flag_z
);
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] result;
  logic              c_new;
  logic              dc_new;
  flag_upd_t         upd;
  logic              fire;

  // Handshake: W-bound operations never stall; file-bound ones wait on the port.
  assign op_ready = dst_file ? wr_ready : 1'b1;
  assign wr_valid = op_valid && dst_file;
  assign wr_data  = result;
  assign fire     = op_valid && op_ready;

  acc_alu_datapath #(.DW(DATA_W), .NW(NIB_W)) u_dp (
    .op        (op_code),
    .src       (src_sel),
    .file_data (file_data),
    .lit_data  (lit_data),
    .w_val     (w_q),
    .c_in      (flag_c),
    .operand   (operand),
    .result    (result),
    .c_out     (c_new),
    .dc_out    (dc_new),
    .upd       (upd)
  );

  acc_alu_flags #(.DW(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .upd    (upd),
    .c_new  (c_new),
    .dc_new (dc_new),
    .result (result),
    .c_q    (flag_c),
    .dc_q   (flag_dc),
    .z_q    (flag_z)
  );

  acc_alu_wreg #(.DW(DATA_W)) u_wreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire && !dst_file),
    .d     (result),
    .q     (w_q)
  );

  assert_sub_noborrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_code == OP_SUB) |=> (flag_c == ($past(operand) >= $past(w_q))));

  assert_rot_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op_code == OP_RL || op_code == OP_RR)) |=> ($stable(flag_z) && $stable(flag_dc)));

  assert_logic_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_code inside {OP_AND, OP_OR, OP_XOR, OP_COM, OP_MOV}) |=> ($stable(flag_c) && $stable(flag_dc)));

  assert_file_w_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dst_file) |=> $stable(w_q));

  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_file && !wr_ready) |-> !op_ready);

  assert_wport_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && dst_file) |-> !wr_valid);

  assert_z_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_code <= 4'd6) |=> (flag_z == ($past(wr_data) == '0)));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [3:0] op_code = '0;
  logic [1:0] src_sel = '0;
  logic       dst_file = 1'b0;
  logic [7:0] file_data = '0;
  logic [7:0] lit_data = '0;
  logic       wr_valid;
  logic       wr_ready = 1'b0;
  logic [7:0] wr_data;
  logic [7:0] w_q;
  logic       flag_c, flag_dc, flag_z;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_w = '0;
  logic       m_c = 1'b0, m_dc = 1'b0, m_z = 1'b0;

  always #4 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .src_sel(src_sel), .dst_file(dst_file),
    .file_data(file_data), .lit_data(lit_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .w_q(w_q),
    .flag_c(flag_c), .flag_dc(flag_dc), .flag_z(flag_z)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Run one operation; expected values follow R2..R11.
  task automatic run(input string req, input logic [3:0] op, input logic [1:0] src,
                     input logic dst, input logic [7:0] f, input logic [7:0] l, input logic rdy);
    logic [7:0] opd, res;
    logic [8:0] s;
    logic [4:0] n;
    logic       nc, ndc, nz, accept;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; src_sel = src; dst_file = dst;
    file_data = f; lit_data = l; wr_ready = rdy;
    opd = (src == 2'd1) ? l : (src == 2'd2) ? m_w : f;
    res = opd; nc = m_c; ndc = m_dc; nz = m_z;
    case (op)
      4'd0: begin s = opd + m_w; n = opd[3:0] + m_w[3:0]; res = s[7:0]; nc = s[8]; ndc = n[4]; nz = (res == 0); end
      4'd1: begin res = opd - m_w; nc = (opd >= m_w); ndc = (opd[3:0] >= m_w[3:0]); nz = (res == 0); end
      4'd2: begin res = opd & m_w; nz = (res == 0); end
      4'd3: begin res = opd | m_w; nz = (res == 0); end
      4'd4: begin res = opd ^ m_w; nz = (res == 0); end
      4'd5: begin res = ~opd; nz = (res == 0); end
      4'd6: begin res = opd; nz = (res == 0); end
      4'd7: begin res = {opd[6:0], m_c}; nc = opd[7]; end
      4'd8: begin res = {m_c, opd[7:1]}; nc = opd[0]; end
      default: res = opd;
    endcase
    accept = !dst || rdy;
    #1;
    check(req, "op_ready", {7'd0, op_ready}, {7'd0, accept});
    check(req, "wr_valid", {7'd0, wr_valid}, {7'd0, dst});
    if (dst) check(req, "wr_data", wr_data, res);
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    if (accept) begin
      if (!dst) m_w = res;
      m_c = nc; m_dc = ndc; m_z = nz;
    end
    check(req, "w_q", w_q, m_w);
    check(req, "flag_c", {7'd0, flag_c}, {7'd0, m_c});
    check(req, "flag_dc", {7'd0, flag_dc}, {7'd0, m_dc});
    check(req, "flag_z", {7'd0, flag_z}, {7'd0, m_z});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "w_q", w_q, 8'h00);
    check("R1", "flags", {5'd0, flag_c, flag_dc, flag_z}, 8'h00);
    check("R1", "wr_valid", {7'd0, wr_valid}, 8'h00);
  endtask

  task automatic t_add;
    run("R7", 4'd6, 2'd1, 1'b0, 8'h00, 8'h0F, 1'b0); // W = 0x0F via literal
    run("R2", 4'd0, 2'd0, 1'b0, 8'h01, 8'h00, 1'b0); // 0x10: DC
    run("R2", 4'd0, 2'd1, 1'b0, 8'h00, 8'hF0, 1'b0); // 0x100: C,Z
    run("R2", 4'd0, 2'd1, 1'b0, 8'h00, 8'h21, 1'b0); // plain
  endtask

  task automatic t_sub;
    run("R7", 4'd6, 2'd1, 1'b0, 8'h00, 8'h03, 1'b0);
    run("R3", 4'd1, 2'd0, 1'b1, 8'h05, 8'h00, 1'b1); // 5-3
    run("R3", 4'd1, 2'd0, 1'b1, 8'h02, 8'h00, 1'b1); // borrow
    run("R3", 4'd1, 2'd0, 1'b1, 8'h03, 8'h00, 1'b1); // zero
    run("R3", 4'd1, 2'd0, 1'b1, 8'h11, 8'h00, 1'b1); // nibble borrow only
    run("R3", 4'd1, 2'd2, 1'b0, 8'h00, 8'h00, 1'b0); // W-W
  endtask

  task automatic t_logic;
    run("R7", 4'd6, 2'd1, 1'b0, 8'h00, 8'hFF, 1'b0);
    run("R2", 4'd0, 2'd1, 1'b0, 8'h00, 8'hFF, 1'b0); // sets C and DC
    run("R5", 4'd2, 2'd1, 1'b0, 8'h00, 8'h0F, 1'b0);
    run("R5", 4'd3, 2'd0, 1'b0, 8'h30, 8'h00, 1'b0);
    run("R5", 4'd4, 2'd2, 1'b0, 8'h00, 8'h00, 1'b0);
    run("R4", 4'd5, 2'd1, 1'b1, 8'h00, 8'hFF, 1'b1);
    run("R5", 4'd5, 2'd1, 1'b0, 8'h00, 8'h5A, 1'b0);
  endtask

  task automatic t_rotate;
    run("R6", 4'd7, 2'd1, 1'b0, 8'h00, 8'h81, 1'b0);
    run("R6", 4'd7, 2'd2, 1'b0, 8'h00, 8'h00, 1'b0);
    run("R6", 4'd8, 2'd1, 1'b1, 8'h00, 8'h01, 1'b1);
    run("R6", 4'd8, 2'd0, 1'b0, 8'h02, 8'h00, 1'b0);
  endtask

  task automatic t_dest;
    run("R8", 4'd6, 2'd0, 1'b0, 8'hA5, 8'h00, 1'b0);
    run("R9", 4'd6, 2'd1, 1'b1, 8'h00, 8'h3C, 1'b1);
    run("R10", 4'd0, 2'd1, 1'b1, 8'h00, 8'h77, 1'b0);
    run("R10", 4'd1, 2'd0, 1'b1, 8'h01, 8'h00, 1'b0);
    run("R11", 4'd12, 2'd1, 1'b0, 8'h00, 8'h00, 1'b0);
    run("R11", 4'd9, 2'd3, 1'b1, 8'h99, 8'h00, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_rotate();
        t_dest();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule